// File: doc/BRIEF.md
# Dual-Channel Staged Converter Command Decoder

This block receives complete 24-bit command words, one per cycle, each marked by a strobe. It holds the digital state of a two-channel converter. Each channel has a staging buffer and an active register. Both hold a 16-bit code and a 2-bit power mode. Every accepted word writes one staging buffer, chosen by a select bit. The word then copies staging contents into the active register of each channel whose load bit is set. A single word can therefore stage one channel and update the other channel, or both channels at once.

The active registers drive the outputs: a code and a power mode per channel. Each channel also has a one-cycle pulse that marks a load of its active register. A word whose reserved bits are not zero is rejected as a whole, and the block raises a one-cycle error pulse.

Top module: `dual_dac_stager`

Word layout, from the most significant bit down:

| Bits | Meaning |
|---|---|
| 23:22 | must be zero |
| 21 | load channel B |
| 20 | load channel A |
| 19 | ignored |
| 18 | buffer select (0 = A, 1 = B) |
| 17:16 | power field |
| 15:0 | code |

## Requirements
- R1: Reset sets both staging buffers and both active registers to code 0 and mode 00. All pulses are low after reset.
- R2: A word with both load bits at 0 changes no output. An idle cycle with no strobe also changes no output.
- R3: A load bit set in a word takes effect in the cycle after the strobe. The loaded channel's active register receives its staging buffer, including any value that the same word wrote.
- R4: A load of the channel whose buffer the word did not select copies that channel's earlier staged contents.
- R5: When both load bits (21 and 20) are set, both channels update in the same cycle.
- R6: Power field 00 writes the code into the selected buffer and sets its mode to normal. Any other power field writes only the mode and leaves the buffer's code unchanged. The modes are: 01 = 1 kΩ to ground, 10 = 100 kΩ to ground, 11 = high impedance.
- R7: A powered-down channel returns to mode 00 only when a word writes its buffer with power field 00 and loads it. A load without such a write keeps the channel powered down.
- R8: A strobed word with bit 23 or bit 22 set changes no buffer and no active register. It raises the error output for exactly one cycle, in the cycle after the strobe, with no load pulse.
- R9: Each channel's updated output is high for exactly one cycle, in the cycle after an accepted word whose load bit for that channel is set, and is low at all other times.
- R10: The value of bit 19 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmd_valid | input | 1 | marks a complete word on cmd_word |
| cmd_word | input | 24 | command word |
| a_code | output | 16 | channel A active code |
| a_mode | output | 2 | channel A active power mode |
| b_code | output | 16 | channel B active code |
| b_mode | output | 2 | channel B active power mode |
| a_updated | output | 1 | channel A loaded in the previous cycle |
| b_updated | output | 1 | channel B loaded in the previous cycle |
| cmd_error | output | 1 | previous word had a reserved bit set |

## Verification
Staging buffers have no port of their own, so the bench can only see their contents through a later load. The hardest cases are a rejected word and a power-down write, because each must leave a buffer's code untouched. To reach them, the stimulus follows each such word with a load-only command: that word writes the other channel's buffer and loads the channel under test. Any hidden change to the buffer then shows up on the outputs. The same kind of load-only word also checks that a powered-down channel stays down until it receives a normal-mode write together with a load.

// File: rtl/dual_dac_stager.sv
module dual_dac_stager #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CODE_W+7:0] cmd_word,
  output logic [CODE_W-1:0] a_code,
  output logic [1:0]        a_mode,
  output logic [CODE_W-1:0] b_code,
  output logic [1:0]        b_mode,
  output logic              a_updated,
  output logic              b_updated,
  output logic              cmd_error
);
  localparam int WORD_W = CODE_W + 8;

  logic [CODE_W-1:0] stg_code [2];
  logic [1:0]        stg_mode [2];
  logic [CODE_W-1:0] nxt_code [2];
  logic [1:0]        nxt_mode [2];
  logic [CODE_W-1:0] act_code [2];
  logic [1:0]        act_mode [2];
  logic [1:0]        upd;

  wire       ok  = cmd_valid && (cmd_word[WORD_W-1 -: 2] == 2'b00);
  wire [1:0] ld  = cmd_word[CODE_W+5 -: 2] & {2{ok}};
  wire       sel = cmd_word[CODE_W+2];
  wire [1:0] pd  = cmd_word[CODE_W+1 -: 2];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      nxt_code[i] = stg_code[i];
      nxt_mode[i] = stg_mode[i];
      if (ok && (sel == 1'(i))) begin
        nxt_mode[i] = pd;
        if (pd == 2'b00) nxt_code[i] = cmd_word[CODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        stg_code[i] <= '0;
        stg_mode[i] <= 2'b00;
        act_code[i] <= '0;
        act_mode[i] <= 2'b00;
      end
      upd       <= 2'b00;
      cmd_error <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        stg_code[i] <= nxt_code[i];
        stg_mode[i] <= nxt_mode[i];
        if (ld[i]) begin
          act_code[i] <= nxt_code[i];
          act_mode[i] <= nxt_mode[i];
        end
      end
      upd       <= ld;
      cmd_error <= cmd_valid && !ok;
    end
  end

  assign a_code    = act_code[0];
  assign a_mode    = act_mode[0];
  assign b_code    = act_code[1];
  assign b_mode    = act_mode[1];
  assign a_updated = upd[0];
  assign b_updated = upd[1];
endmodule

// File: rtl/dual_dac_stager_chk.sv
module dual_dac_stager_chk #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [CODE_W+7:0] cmd_word,
  input logic [CODE_W-1:0] a_code,
  input logic [1:0]        a_mode,
  input logic [CODE_W-1:0] b_code,
  input logic [1:0]        b_mode,
  input logic              a_updated,
  input logic              b_updated,
  input logic              cmd_error
);
  localparam int WORD_W = CODE_W + 8;

  wire rsv_bad = cmd_word[WORD_W-1 -: 2] != 2'b00;

  assert_a_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !a_updated |-> ($stable(a_code) && $stable(a_mode)));
  assert_b_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !b_updated |-> ($stable(b_code) && $stable(b_mode)));
  assert_err_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_error |-> ($past(cmd_valid) && $past(rsv_bad)));
  assert_err_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_error |-> (!a_updated && !b_updated));
  assert_a_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    a_updated |-> ($past(cmd_valid) && !$past(rsv_bad) && $past(cmd_word[CODE_W+4])));
  assert_b_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    b_updated |-> ($past(cmd_valid) && !$past(rsv_bad) && $past(cmd_word[CODE_W+5])));
  assert_both_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !rsv_bad && cmd_word[CODE_W+5] && cmd_word[CODE_W+4]) |=> (a_updated && b_updated));
endmodule

bind dual_dac_stager dual_dac_stager_chk #(.CODE_W(CODE_W)) chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .a_code(a_code), .a_mode(a_mode), .b_code(b_code), .b_mode(b_mode),
  .a_updated(a_updated), .b_updated(b_updated), .cmd_error(cmd_error)
);

// File: tb/dual_dac_stager_test.sv
module dual_dac_stager_test;
  typedef struct {
    logic [15:0] ac; logic [1:0] am;
    logic [15:0] bc; logic [1:0] bm;
    logic la; logic lb; logic er;
    string req;
  } exp_t;

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [23:0] cmd_word = '0;
  logic [15:0] a_code, b_code;
  logic [1:0]  a_mode, b_mode;
  logic a_updated, b_updated, cmd_error;

  int total = 0, bad = 0;
  bit done = 0;
  exp_t q[$];
  exp_t last;

  logic [15:0] m_sc [2];
  logic [1:0]  m_sm [2];
  logic [15:0] m_ac [2];
  logic [1:0]  m_am [2];

  always #10 clk = ~clk;

  dual_dac_stager uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .a_code(a_code), .a_mode(a_mode), .b_code(b_code), .b_mode(b_mode),
    .a_updated(a_updated), .b_updated(b_updated), .cmd_error(cmd_error)
  );

  task automatic cmp(exp_t e, string tag);
    total++;
    if (a_code !== e.ac || a_mode !== e.am || b_code !== e.bc || b_mode !== e.bm ||
        a_updated !== e.la || b_updated !== e.lb || cmd_error !== e.er) begin
      bad++;
      $display("FAIL %s: got A=%h/%b B=%h/%b upd=%b%b err=%b exp A=%h/%b B=%h/%b upd=%b%b err=%b",
               tag, a_code, a_mode, b_code, b_mode, a_updated, b_updated, cmd_error,
               e.ac, e.am, e.bc, e.bm, e.la, e.lb, e.er);
    end
  endtask

  task automatic send(logic [23:0] w, string req);
    exp_t e;
    bit good;
    logic [1:0] ld;
    int s;
    good = (w[23:22] == 2'b00);
    ld = {w[21], w[20]};
    s = w[18] ? 1 : 0;
    if (good) begin
      if (w[17:16] == 2'b00) begin m_sc[s] = w[15:0]; m_sm[s] = 2'b00; end
      else m_sm[s] = w[17:16];
      for (int i = 0; i < 2; i++)
        if (ld[i]) begin m_ac[i] = m_sc[i]; m_am[i] = m_sm[i]; end
    end
    e.ac = m_ac[0]; e.am = m_am[0]; e.bc = m_ac[1]; e.bm = m_am[1];
    e.la = good && ld[0]; e.lb = good && ld[1]; e.er = !good; e.req = req;
    @(negedge clk);
    cmd_valid = 1; cmd_word = w;
    @(posedge clk);
    q.push_back(e);
    @(negedge clk);
    cmd_valid = 0; cmd_word = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (q.size() > 0) begin
          last = q.pop_front();
          cmp(last, last.req);
        end else if (last.req != "") begin
          exp_t idle;
          idle = last; idle.la = 0; idle.lb = 0; idle.er = 0;
          cmp(idle, "R2/R9 idle");
        end
      end
    end
  end

  initial begin
    exp_t z;
    last.req = "";
    for (int i = 0; i < 2; i++) begin
      m_sc[i] = 0; m_sm[i] = 0; m_ac[i] = 0; m_am[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    z.ac = 0; z.am = 0; z.bc = 0; z.bm = 0; z.la = 0; z.lb = 0; z.er = 0; z.req = "R1 reset";
    #1 cmp(z, "R1 reset");
    send(24'h00_1234, "R2 stage A no load");
    send(24'h14_BEEF, "R3 write B load A");
    send(24'h20_5555, "R4 write A load B uses staged B");
    send(24'h34_0F0F, "R5 write B load both");
    send(24'h11_FFFF, "R6 pd 01 keeps code");
    send(24'h2C_2222, "R10 bit19 set write B load B");
    send(24'h14_3333, "R7 load A without normal write");
    send(24'hB0_7777, "R8 reserved bit23");
    send(24'h70_7777, "R8 reserved bit22");
    send(24'h14_3333, "R8 buffer A untouched");
    send(24'h10_9ABC, "R7 normal write and load exits power-down");
    send(24'h27_ABCD, "R6 pd 11 B");
    send(24'h36_0000, "R5 pd 10 B load both");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule